// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out one atomic memory operation at a time for a processor core. It is handed a decoded request: a five-bit operation code, an access width, acquire and release ordering bits, an address and a source operand. It reads the addressed location and combines the value it reads with the operand. It then writes the combined value back to the same location and returns the value that memory held before the operation, so that the core can place it in the destination register.

The memory side is a valid/ready request channel with a separate response channel. A lock output is held from the moment the read request is raised until the write response comes back, so an external arbiter can keep other masters away from the location. Width and alignment are checked before the bus is touched. A fault on either access ends the operation with an exception and no register update. A write that the memory rejects is reported on a separate internal-error flag, because an atomic write should never be refused.

Top module: `amo_rmw_unit`

## Requirements
- R1: An operation code is accepted only if it is one of add 00000, swap 00001, xor 00100, or 01000, and 01100, min 10000, max 10100, minu 11000, maxu 11100. The width code must be word (2'b10), or doubleword (2'b11) when XLEN is at least 64. Any other request completes with `rsp_cause` 3 (illegal), and no memory request is made.
- R2: A word request with address bits [1:0] not zero, or a doubleword request with address bits [2:0] not zero, completes with `rsp_cause` 1 (misaligned), and no memory request is made.
- R3: A legal, aligned request makes exactly one read request (`mem_req_we`=0) and then one write request (`mem_req_we`=1), both to the request address and carrying the width code on `mem_req_size`. `mem_lock` is high from the read request until the write response arrives. It is low whenever the unit is idle or responding.
- R4: The read request carries `mem_req_acq`=aq and `mem_req_rel`=rl. The write request carries `mem_req_acq`=aq AND rl and `mem_req_rel`=rl.
- R5: Swap writes the operand. Add, xor, and, or write the operand combined with the loaded value (add wraps at the access width).
- R6: Min and max compare the operand and the loaded value as signed numbers, each sign-extended from the access width.
- R7: Minu and maxu compare the operand and the loaded value as unsigned numbers, each zero-extended from the access width.
- R8: Only the access-width bits of the result are written. For a word access, `mem_req_wdata[31:0]` holds the result and the upper bits are zero. Only bits [31:0] of the read data are used for a word access.
- R9: On success `rsp_rd_we`=1 and `rsp_rd` is the old memory value sign-extended from the access width, for every operation including minu and maxu.
- R10: A fault on the read response completes with `rsp_cause` 2 and no write request. A fault on the write response completes with `rsp_cause` 2. In both cases `rsp_rd_we`=0.
- R11: A reject on the write response completes with `rsp_int_err`=1, `rsp_exc`=0 and `rsp_rd_we`=0.
- R12: `rsp_valid` is a single-cycle pulse per request. `req_ready` is high only while idle, and a new request can be accepted in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_fn | input | 5 | Operation code |
| req_size | input | 2 | Width code: 2 word, 3 doubleword |
| req_aq | input | 1 | Acquire ordering bit |
| req_rl | input | 1 | Release ordering bit |
| req_addr | input | XLEN | Target address |
| req_rs2 | input | XLEN | Source operand |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rd | output | XLEN | Old memory value, sign-extended |
| rsp_rd_we | output | 1 | Destination register is to be written |
| rsp_exc | output | 1 | Exception raised |
| rsp_cause | output | 2 | 0 none, 1 misaligned, 2 access fault, 3 illegal |
| rsp_int_err | output | 1 | Write was rejected |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | XLEN | Memory address |
| mem_req_size | output | 2 | Width code of the access |
| mem_req_wdata | output | XLEN | Write data |
| mem_req_acq | output | 1 | Acquire attribute |
| mem_req_rel | output | 1 | Release attribute |
| mem_lock | output | 1 | Bus lock across the read and the write |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | XLEN | Read data |
| mem_rsp_fault | input | 1 | Access fault |
| mem_rsp_reject | input | 1 | Write rejected |

## Verification
An exception found at decode shows on `rsp_valid` in the cycle right after the accepting edge. For a legal request, the read request shows in that same cycle, the write request follows the cycle after the read response is taken, and the completion pulse follows the cycle after the write response is taken. The bench drives every input and samples every output on the falling clock edge. It waits for each of these events with bounded polling loops, so random ready and response delays never shift a sample. Each step is checked in the cycle it is due: attributes and data on the request itself, lock during every wait, and result fields on the pulse.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam logic [4:0] FN_ADD  = 5'b00000;
    localparam logic [4:0] FN_SWAP = 5'b00001;
    localparam logic [4:0] FN_XOR  = 5'b00100;
    localparam logic [4:0] FN_OR   = 5'b01000;
    localparam logic [4:0] FN_AND  = 5'b01100;
    localparam logic [4:0] FN_MIN  = 5'b10000;
    localparam logic [4:0] FN_MAX  = 5'b10100;
    localparam logic [4:0] FN_MINU = 5'b11000;
    localparam logic [4:0] FN_MAXU = 5'b11100;

    localparam logic [1:0] SZ_WORD = 2'b10;
    localparam logic [1:0] SZ_DBL  = 2'b11;

    localparam logic [1:0] CAUSE_NONE     = 2'd0;
    localparam logic [1:0] CAUSE_MISALIGN = 2'd1;
    localparam logic [1:0] CAUSE_FAULT    = 2'd2;
    localparam logic [1:0] CAUSE_ILLEGAL  = 2'd3;

    typedef enum logic [3:0] {
        K_SWAP, K_ADD, K_XOR, K_AND, K_OR, K_MIN, K_MAX, K_MINU, K_MAXU
    } amo_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_WAIT_READ, ST_WRITE, ST_WAIT_WRITE, ST_DONE
    } amo_state_e;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [4:0] fn,
    input  logic [1:0] size,
    input  logic [2:0] addr_lo,
    output logic       legal,
    output logic       misaligned,
    output logic       is_dbl,
    output amo_kind_e  kind
);
    localparam bit DBL_OK = (XLEN >= 64);

    logic fn_ok;
    logic size_ok;

    always_comb begin
        fn_ok = 1'b1;
        kind  = K_SWAP;
        case (fn)
            FN_SWAP: kind = K_SWAP;
            FN_ADD:  kind = K_ADD;
            FN_XOR:  kind = K_XOR;
            FN_AND:  kind = K_AND;
            FN_OR:   kind = K_OR;
            FN_MIN:  kind = K_MIN;
            FN_MAX:  kind = K_MAX;
            FN_MINU: kind = K_MINU;
            FN_MAXU: kind = K_MAXU;
            default: fn_ok = 1'b0;
        endcase
    end

    always_comb begin
        is_dbl     = (size == SZ_DBL);
        size_ok    = (size == SZ_WORD) || (is_dbl && DBL_OK);
        legal      = fn_ok && size_ok;
        misaligned = is_dbl ? (addr_lo != 3'b000) : (addr_lo[1:0] != 2'b00);
    end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  amo_kind_e         kind,
    input  logic              is_dbl,
    input  logic [XLEN-1:0]   operand,
    input  logic [XLEN-1:0]   loaded,
    output logic [XLEN-1:0]   wdata,
    output logic [XLEN-1:0]   old_ext
);
    logic            uns;
    logic [XLEN-1:0] a_ext;
    logic [XLEN-1:0] b_ext;
    logic [XLEN-1:0] result;
    logic            a_lt_s;
    logic            a_lt_u;

    assign uns = (kind == K_MINU) || (kind == K_MAXU);

    generate
        if (XLEN > 32) begin : g_wide
            localparam int UPPER = XLEN - 32;
            assign a_ext   = is_dbl ? operand
                           : {{UPPER{~uns & operand[31]}}, operand[31:0]};
            assign b_ext   = is_dbl ? loaded
                           : {{UPPER{~uns & loaded[31]}}, loaded[31:0]};
            assign wdata   = is_dbl ? result : {{UPPER{1'b0}}, result[31:0]};
            assign old_ext = is_dbl ? loaded : {{UPPER{loaded[31]}}, loaded[31:0]};
        end else begin : g_narrow
            assign a_ext   = operand;
            assign b_ext   = loaded;
            assign wdata   = result;
            assign old_ext = loaded;
        end
    endgenerate

    assign a_lt_s = $signed(a_ext) < $signed(b_ext);
    assign a_lt_u = a_ext < b_ext;

    always_comb begin
        case (kind)
            K_SWAP:  result = a_ext;
            K_ADD:   result = a_ext + b_ext;
            K_XOR:   result = a_ext ^ b_ext;
            K_AND:   result = a_ext & b_ext;
            K_OR:    result = a_ext | b_ext;
            K_MIN:   result = a_lt_s ? a_ext : b_ext;
            K_MAX:   result = a_lt_s ? b_ext : a_ext;
            K_MINU:  result = a_lt_u ? a_ext : b_ext;
            K_MAXU:  result = a_lt_u ? b_ext : a_ext;
            default: result = a_ext;
        endcase
    end

endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [4:0]      req_fn,
    input  logic [1:0]      req_size,
    input  logic            req_aq,
    input  logic            req_rl,
    input  logic [XLEN-1:0] req_addr,
    input  logic [XLEN-1:0] req_rs2,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_rd,
    output logic            rsp_rd_we,
    output logic            rsp_exc,
    output logic [1:0]      rsp_cause,
    output logic            rsp_int_err,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_we,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [1:0]      mem_req_size,
    output logic [XLEN-1:0] mem_req_wdata,
    output logic            mem_req_acq,
    output logic            mem_req_rel,
    output logic            mem_lock,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_rdata,
    input  logic            mem_rsp_fault,
    input  logic            mem_rsp_reject
);

    typedef struct packed {
        amo_state_e      st;
        amo_kind_e       kind;
        logic            dbl;
        logic            aq;
        logic            rl;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] opnd;
        logic [XLEN-1:0] wdata;
        logic [XLEN-1:0] rd;
        logic            rd_we;
        logic [1:0]      cause;
        logic            ierr;
    } ctx_t;

    ctx_t ctx_d;
    ctx_t ctx_q;

    logic            dec_legal;
    logic            dec_mis;
    logic            dec_dbl;
    amo_kind_e       dec_kind;
    logic [XLEN-1:0] alu_wdata;
    logic [XLEN-1:0] alu_old;

    amo_decode #(.XLEN(XLEN)) u_decode (
        .fn         (req_fn),
        .size       (req_size),
        .addr_lo    (req_addr[2:0]),
        .legal      (dec_legal),
        .misaligned (dec_mis),
        .is_dbl     (dec_dbl),
        .kind       (dec_kind)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .kind    (ctx_q.kind),
        .is_dbl  (ctx_q.dbl),
        .operand (ctx_q.opnd),
        .loaded  (mem_rsp_rdata),
        .wdata   (alu_wdata),
        .old_ext (alu_old)
    );

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.kind  = dec_kind;
                    ctx_d.dbl   = dec_dbl;
                    ctx_d.aq    = req_aq;
                    ctx_d.rl    = req_rl;
                    ctx_d.addr  = req_addr;
                    ctx_d.opnd  = req_rs2;
                    ctx_d.wdata = '0;
                    ctx_d.rd    = '0;
                    ctx_d.rd_we = 1'b0;
                    ctx_d.cause = CAUSE_NONE;
                    ctx_d.ierr  = 1'b0;
                    if (!dec_legal) begin
                        ctx_d.cause = CAUSE_ILLEGAL;
                        ctx_d.st    = ST_DONE;
                    end else if (dec_mis) begin
                        ctx_d.cause = CAUSE_MISALIGN;
                        ctx_d.st    = ST_DONE;
                    end else begin
                        ctx_d.st    = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (mem_req_ready) ctx_d.st = ST_WAIT_READ;
            end
            ST_WAIT_READ: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_fault) begin
                        ctx_d.cause = CAUSE_FAULT;
                        ctx_d.st    = ST_DONE;
                    end else begin
                        ctx_d.wdata = alu_wdata;
                        ctx_d.rd    = alu_old;
                        ctx_d.st    = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_req_ready) ctx_d.st = ST_WAIT_WRITE;
            end
            ST_WAIT_WRITE: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_fault) begin
                        ctx_d.cause = CAUSE_FAULT;
                    end else if (mem_rsp_reject) begin
                        ctx_d.ierr  = 1'b1;
                    end else begin
                        ctx_d.rd_we = 1'b1;
                    end
                    ctx_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                ctx_d.st = ST_IDLE;
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, kind: K_SWAP, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        req_ready     = (ctx_q.st == ST_IDLE);
        mem_req_valid = (ctx_q.st == ST_READ) || (ctx_q.st == ST_WRITE);
        mem_req_we    = (ctx_q.st == ST_WRITE);
        mem_req_addr  = ctx_q.addr;
        mem_req_size  = ctx_q.dbl ? SZ_DBL : SZ_WORD;
        mem_req_wdata = (ctx_q.st == ST_WRITE) ? ctx_q.wdata : '0;
        mem_req_acq   = (ctx_q.st == ST_READ) ? ctx_q.aq : (ctx_q.aq & ctx_q.rl);
        mem_req_rel   = ctx_q.rl;
        mem_lock      = (ctx_q.st == ST_READ) || (ctx_q.st == ST_WAIT_READ)
                     || (ctx_q.st == ST_WRITE) || (ctx_q.st == ST_WAIT_WRITE);
        rsp_valid     = (ctx_q.st == ST_DONE);
        rsp_rd        = ctx_q.rd;
        rsp_rd_we     = ctx_q.rd_we;
        rsp_cause     = ctx_q.cause;
        rsp_exc       = (ctx_q.cause != CAUSE_NONE);
        rsp_int_err   = ctx_q.ierr;
    end

endmodule

// File: rtl/amo_rmw_chk.sv
module amo_rmw_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic            mem_req_we,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            mem_req_acq,
    input logic            mem_req_rel,
    input logic            mem_lock,
    input logic            rsp_valid,
    input logic            rsp_exc,
    input logic            rsp_rd_we,
    input logic            rsp_int_err
);

    a_r3_lock_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_lock);

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    a_r3_unlock_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> rsp_valid);

    a_r4_wr_acq_needs_rel: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we && mem_req_acq |-> mem_req_rel);

    a_r10_exc_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_exc |-> !rsp_rd_we);

    a_r11_ierr_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_int_err |-> !rsp_rd_we && !rsp_exc);

    a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock || rsp_valid) |-> !req_ready);

endmodule

bind amo_rmw_unit amo_rmw_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_acq   (mem_req_acq),
    .mem_req_rel   (mem_req_rel),
    .mem_lock      (mem_lock),
    .rsp_valid     (rsp_valid),
    .rsp_exc       (rsp_exc),
    .rsp_rd_we     (rsp_rd_we),
    .rsp_int_err   (rsp_int_err)
);

// File: tb/amo_rmw_unit_test.sv
module amo_rmw_unit_test;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [4:0]      req_fn = '0;
    logic [1:0]      req_size = '0;
    logic            req_aq = 1'b0;
    logic            req_rl = 1'b0;
    logic [XLEN-1:0] req_addr = '0;
    logic [XLEN-1:0] req_rs2 = '0;
    logic            rsp_valid;
    logic [XLEN-1:0] rsp_rd;
    logic            rsp_rd_we;
    logic            rsp_exc;
    logic [1:0]      rsp_cause;
    logic            rsp_int_err;
    logic            mem_req_valid;
    logic            mem_req_ready = 1'b0;
    logic            mem_req_we;
    logic [XLEN-1:0] mem_req_addr;
    logic [1:0]      mem_req_size;
    logic [XLEN-1:0] mem_req_wdata;
    logic            mem_req_acq;
    logic            mem_req_rel;
    logic            mem_lock;
    logic            mem_rsp_valid = 1'b0;
    logic [XLEN-1:0] mem_rsp_rdata = '0;
    logic            mem_rsp_fault = 1'b0;
    logic            mem_rsp_reject = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    amo_rmw_unit #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_fn(req_fn),
        .req_size(req_size), .req_aq(req_aq), .req_rl(req_rl),
        .req_addr(req_addr), .req_rs2(req_rs2),
        .rsp_valid(rsp_valid), .rsp_rd(rsp_rd), .rsp_rd_we(rsp_rd_we),
        .rsp_exc(rsp_exc), .rsp_cause(rsp_cause), .rsp_int_err(rsp_int_err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
        .mem_req_acq(mem_req_acq), .mem_req_rel(mem_req_rel),
        .mem_lock(mem_lock), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_fault(mem_rsp_fault),
        .mem_rsp_reject(mem_rsp_reject)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit fn_known(input logic [4:0] f);
        return f == 5'b00000 || f == 5'b00001 || f == 5'b00100 ||
               f == 5'b01000 || f == 5'b01100 || f == 5'b10000 ||
               f == 5'b10100 || f == 5'b11000 || f == 5'b11100;
    endfunction

    function automatic logic [63:0] widen(input logic [63:0] v, input bit dbl, input bit uns);
        if (dbl) return v;
        if (uns) return {32'h0, v[31:0]};
        return {{32{v[31]}}, v[31:0]};
    endfunction

    function automatic logic [63:0] model_new(input logic [4:0] f, input bit dbl,
                                              input logic [63:0] rs2, input logic [63:0] mem);
        bit uns = (f == 5'b11000) || (f == 5'b11100);
        logic [63:0] a = widen(rs2, dbl, uns);
        logic [63:0] b = widen(mem, dbl, uns);
        longint sa = longint'(a);
        longint sb = longint'(b);
        logic [63:0] r;
        case (f)
            5'b00001: r = a;
            5'b00000: r = a + b;
            5'b00100: r = a ^ b;
            5'b01100: r = a & b;
            5'b01000: r = a | b;
            5'b10000: r = (sa < sb) ? a : b;
            5'b10100: r = (sa > sb) ? a : b;
            5'b11000: r = (a < b) ? a : b;
            default:  r = (a > b) ? a : b;
        endcase
        if (!dbl) r = {32'h0, r[31:0]};
        return r;
    endfunction

    function automatic string op_tag(input logic [4:0] f);
        if (f == 5'b10000 || f == 5'b10100) return "R6";
        if (f == 5'b11000 || f == 5'b11100) return "R7";
        return "R5";
    endfunction

    bit saw_mem;

    task automatic wait_mem(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (mem_req_valid) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_rsp(output bit ok);
        ok = 1'b0;
        saw_mem = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (mem_req_valid) saw_mem = 1'b1;
            if (rsp_valid) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic handshake_and_respond(input logic [63:0] rdata, input bit flt, input bit rej);
        int d = int'($urandom_range(0, 2));
        for (int i = 0; i < d; i++) @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        d = int'($urandom_range(0, 3));
        for (int i = 0; i < d; i++) begin
            chk(mem_lock === 1'b1, "R3 lock during wait", 64'(mem_lock), 64'd1);
            @(negedge clk);
        end
        mem_rsp_valid  = 1'b1;
        mem_rsp_rdata  = rdata;
        mem_rsp_fault  = flt;
        mem_rsp_reject = rej;
        @(negedge clk);
        mem_rsp_valid  = 1'b0;
        mem_rsp_fault  = 1'b0;
        mem_rsp_reject = 1'b0;
        mem_rsp_rdata  = '0;
    endtask

    task automatic run(input logic [4:0] f, input logic [1:0] sz, input bit aq, input bit rl,
                       input logic [63:0] addr, input logic [63:0] rs2, input logic [63:0] mem,
                       input bit rflt, input bit wflt, input bit wrej);
        bit legal = fn_known(f) && (sz == 2'b10 || sz == 2'b11);
        bit dbl = (sz == 2'b11);
        bit mis = dbl ? (addr[2:0] != 3'b0) : (addr[1:0] != 2'b0);
        bit ok;
        logic [63:0] exp_w = model_new(f, dbl, rs2, mem);
        logic [63:0] exp_rd = dbl ? mem : {{32{mem[31]}}, mem[31:0]};

        @(negedge clk);
        chk(req_ready === 1'b1, "R12 ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_fn = f; req_size = sz; req_aq = aq; req_rl = rl;
        req_addr = addr; req_rs2 = rs2;
        @(negedge clk);
        req_valid = 1'b0;
        req_fn = 5'h1f; req_rs2 = '1; req_addr = '1;

        if (!legal || mis) begin
            wait_rsp(ok);
            chk(ok, "R1/R2 response timeout", 64'(ok), 64'd1);
            if (!legal)
                chk(rsp_cause == 2'd3 && rsp_exc, "R1 illegal cause", 64'(rsp_cause), 64'd3);
            else
                chk(rsp_cause == 2'd1 && rsp_exc, "R2 misaligned cause", 64'(rsp_cause), 64'd1);
            chk(!saw_mem && !rsp_rd_we, "R2 no memory access", 64'(saw_mem), 64'd0);
        end else begin
            wait_mem(ok);
            chk(ok, "R3 read request timeout", 64'(ok), 64'd1);
            chk(mem_req_we === 1'b0 && mem_req_addr === addr && mem_req_size === sz
                && mem_lock === 1'b1, "R3 read request", mem_req_addr, addr);
            chk(mem_req_acq === aq && mem_req_rel === rl, "R4 read attrs",
                64'({mem_req_acq, mem_req_rel}), 64'({aq, rl}));
            handshake_and_respond(mem, rflt, 1'b0);
            if (rflt) begin
                wait_rsp(ok);
                chk(ok && !saw_mem, "R10 read fault no write", 64'(saw_mem), 64'd0);
                chk(rsp_cause == 2'd2 && !rsp_rd_we, "R10 read fault cause",
                    64'(rsp_cause), 64'd2);
            end else begin
                wait_mem(ok);
                chk(ok, "R3 write request timeout", 64'(ok), 64'd1);
                chk(mem_req_we === 1'b1 && mem_req_addr === addr && mem_req_size === sz
                    && mem_lock === 1'b1, "R3 write request", mem_req_addr, addr);
                chk(mem_req_acq === (aq & rl) && mem_req_rel === rl, "R4 write attrs",
                    64'({mem_req_acq, mem_req_rel}), 64'({aq & rl, rl}));
                chk(mem_req_wdata === exp_w, op_tag(f), mem_req_wdata, exp_w);
                if (!dbl)
                    chk(mem_req_wdata[63:32] === 32'h0, "R8 upper bits zero",
                        mem_req_wdata, exp_w);
                handshake_and_respond(mem ^ 64'hA5A5_0000_5A5A_FFFF, wflt, wrej);
                wait_rsp(ok);
                chk(ok, "R3 final response timeout", 64'(ok), 64'd1);
                if (wflt) begin
                    chk(rsp_cause == 2'd2 && !rsp_rd_we, "R10 write fault",
                        64'(rsp_cause), 64'd2);
                end else if (wrej) begin
                    chk(rsp_int_err && !rsp_exc && !rsp_rd_we, "R11 reject flag",
                        64'({rsp_int_err, rsp_exc, rsp_rd_we}), 64'b100);
                end else begin
                    chk(rsp_rd_we && !rsp_exc && !rsp_int_err, "R9 rd write",
                        64'(rsp_rd_we), 64'd1);
                    chk(rsp_rd === exp_rd, "R9 old value", rsp_rd, exp_rd);
                end
            end
            chk(mem_lock === 1'b0, "R3 lock low at response", 64'(mem_lock), 64'd0);
        end
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R12 single pulse",
            64'({rsp_valid, req_ready}), 64'b01);
    endtask

    function automatic logic [4:0] pick_fn(input int k);
        case (k)
            0: return 5'b00000; 1: return 5'b00001; 2: return 5'b00100;
            3: return 5'b01000; 4: return 5'b01100; 5: return 5'b10000;
            6: return 5'b10100; 7: return 5'b11000; default: return 5'b11100;
        endcase
    endfunction

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=done", 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd7311);
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b0 || req_ready === 1'b1, "R12 reset known", 64'(req_ready), 64'd1);
        chk(rsp_valid === 1'b0 && mem_req_valid === 1'b0 && mem_lock === 1'b0,
            "R3 reset idle outputs", 64'({rsp_valid, mem_req_valid, mem_lock}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R12 ready after reset", 64'(req_ready), 64'd1);

        // Directed corners
        run(5'b10000, 2'b10, 0, 0, 64'h100, 64'h0000_0000_FFFF_FFFE, 64'h0000_0000_0000_0003, 0, 0, 0); // R6 neg word
        run(5'b10100, 2'b10, 0, 0, 64'h104, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 0, 0, 0); // R6
        run(5'b11000, 2'b10, 1, 0, 64'h108, 64'h0000_0000_FFFF_FFFF, 64'h1234_5678_0000_0001, 0, 0, 0); // R7
        run(5'b11100, 2'b10, 0, 1, 64'h10C, 64'h0000_0000_0000_0001, 64'h0000_0000_F000_0000, 0, 0, 0); // R7, R9 sign
        run(5'b00000, 2'b10, 1, 1, 64'h110, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 0, 0); // R5 wrap, R8
        run(5'b00000, 2'b11, 1, 1, 64'h118, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 0, 0); // R5 dbl
        run(5'b10000, 2'b11, 0, 0, 64'h120, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 0, 0, 0); // R6 dbl
        run(5'b11100, 2'b11, 0, 0, 64'h128, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 0, 0, 0); // R7 dbl
        run(5'b00010, 2'b10, 0, 0, 64'h130, 64'h1, 64'h2, 0, 0, 0);  // R1 bad code
        run(5'b00001, 2'b01, 0, 0, 64'h130, 64'h1, 64'h2, 0, 0, 0);  // R1 bad width
        run(5'b00001, 2'b10, 0, 0, 64'h132, 64'h1, 64'h2, 0, 0, 0);  // R2 word
        run(5'b00001, 2'b11, 0, 0, 64'h134, 64'h1, 64'h2, 0, 0, 0);  // R2 dbl
        run(5'b00100, 2'b10, 0, 0, 64'h140, 64'h1, 64'h2, 1, 0, 0);  // R10 read fault
        run(5'b01100, 2'b11, 0, 0, 64'h148, 64'h1, 64'h2, 0, 1, 0);  // R10 write fault
        run(5'b01000, 2'b10, 1, 0, 64'h150, 64'h1, 64'h2, 0, 0, 1);  // R11 reject

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [4:0]  f  = ($urandom_range(0, 15) == 0) ? 5'($urandom) : pick_fn(int'($urandom_range(0, 8)));
            logic [1:0]  sz = ($urandom_range(0, 19) == 0) ? 2'($urandom) : {1'b1, 1'($urandom)};
            logic [63:0] ad = {$urandom, $urandom} & ~64'h7;
            int          fk = int'($urandom_range(0, 19));
            if ($urandom_range(0, 9) == 0) ad[2:0] = 3'($urandom);
            run(f, sz, 1'($urandom), 1'($urandom), ad, {$urandom, $urandom}, {$urandom, $urandom},
                fk == 0, fk == 1, fk == 2);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule